// File: doc/BRIEF.md
# Multi-Latency Issue Hazard Controller

This controller sits at the issue stage of an in-order pipeline that feeds five execution units: an integer ALU, a load path, a pipelined floating-point adder, a pipelined multiplier and an unpipelined divider. Each cycle it looks at the decoded instruction: its unit class, its destination register and up to two source registers, each with an enable bit. It then either issues the instruction or stalls it. When it stalls, the instruction and everything behind it stay where they are, because issue is strictly in program order.

Internally it keeps three things:

- A countdown for each register, giving the cycles until that register's pending result arrives.
- A busy countdown for each unit whose initiation interval is above one.
- A shift register of reserved writeback cycles, because the register file has a single write port.

The slot at the head of the shift register drives a writeback strobe and its destination tag.

Operands are read in order at decode, so write-after-read needs no tracking. Read-after-write, write-after-write and structural conflicts (a busy divider or a taken writeback cycle) are all detected.

Top module: `issue_hazard_ctrl`

## Requirements
- R1: `issue` is high exactly when `in_valid` is high and no hazard exists. `stall` is high exactly when `in_valid` is high and a hazard exists. Both are low when `in_valid` is low.
- R2: Unit codes are 0 ALU, 1 load, 2 FP add, 3 multiply and 4 divide, with latencies 0, 1, 3, 6 and 24. An instruction of latency L that issues in cycle t with `in_dst_en` high raises `wb_valid` in cycle t+L+1, with `wb_tag` equal to its destination. In every other cycle `wb_valid` is low.
- R3: An instruction whose enabled source matches a register with a pending write stalls until that write's writeback cycle, and issues in that cycle. A consumer presented one cycle after its producer therefore stalls for exactly the producer's latency.
- R4: The ALU, load, FP add and multiply units accept a new instruction every cycle.
- R5: A divide issued in cycle t blocks any other divide until cycle t+25.
- R6: Only one writeback may happen per cycle. An instruction stalls while its writeback cycle is already reserved.
- R7: A writer to a register with a pending write stalls until its own writeback cycle falls strictly after the earlier one.
- R8: A source whose enable bit is low never causes a stall, whatever register number it carries.
- R9: A synchronous reset clears every pending-write countdown, the divider busy count and all writeback reservations. After reset no writeback strobe appears, and a divide issues at once.
- R10: An instruction with `in_dst_en` low reserves no writeback cycle, creates no pending write and sees no write-after-write or writeback-port stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A decoded instruction is presented |
| in_unit | input | 3 | Unit class code |
| in_dst | input | 5 | Destination register |
| in_dst_en | input | 1 | Instruction writes a register |
| in_src1 | input | 5 | First source register |
| in_src1_en | input | 1 | First source is used |
| in_src2 | input | 5 | Second source register |
| in_src2_en | input | 1 | Second source is used |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held this cycle |
| wb_valid | output | 1 | A result is written back this cycle |
| wb_tag | output | 5 | Destination of the result written back |

## Verification
The bench targets the following corner cases, and each one catches a particular kind of error:

- **Consumer arriving on the producer's writeback cycle.** A controller that counts latency one cycle too long or too short shows an extra stall, or lets the consumer run ahead of its data.
- **Writeback collisions.** A load followed at once by an ALU op collides on one writeback cycle, and so does a multiply followed three cycles later by an add. A design without port arbitration emits one strobe for two results.
- **Write-after-write.** An ALU write that lands on a register the multiplier still owes must wait six cycles. If it does not, the older value overwrites the newer one.
- **Back-to-back divides.** These expose an off-by-one in the busy window.
- **Disabled sources and destinations.** These must not stall.
- **Reset during flight.** In-flight work must vanish without a stray strobe.

A long mixed stream over eight registers compares every cycle against the behavioural model.

// File: rtl/iss_pkg.sv
package iss_pkg;
   localparam int NUM_UNITS = 5;
   localparam int UNIT_W    = 3;

   typedef enum logic [UNIT_W-1:0] {
      UNIT_ALU  = 3'd0,
      UNIT_LOAD = 3'd1,
      UNIT_FADD = 3'd2,
      UNIT_FMUL = 3'd3,
      UNIT_FDIV = 3'd4
   } unit_e;

   function automatic int max5(int a, int b, int c, int d, int e);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      if (e > m) m = e;
      return m;
   endfunction
endpackage

// File: rtl/iss_pend_table.sv
module iss_pend_table #(
   parameter int NUM_REGS = 32,
   parameter int REG_W    = 5,
   parameter int CNT_W    = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [REG_W-1:0] src1,
   input  logic             src1_en,
   input  logic [REG_W-1:0] src2,
   input  logic             src2_en,
   input  logic [REG_W-1:0] dst,
   input  logic             dst_en,
   input  logic [CNT_W-1:0] lat,
   input  logic             set,
   output logic             raw_hit,
   output logic             waw_hit
);
   logic [CNT_W-1:0] remain [NUM_REGS];

   always_ff @(posedge clk) begin
      for (int r = 0; r < NUM_REGS; r++) begin
         if (rst)
            remain[r] <= '0;
         else if (set && dst == REG_W'(r))
            remain[r] <= lat;
         else if (remain[r] != '0)
            remain[r] <= remain[r] - 1'b1;
      end
   end

   always_comb begin
      raw_hit = (src1_en && remain[src1] != '0) || (src2_en && remain[src2] != '0);
      waw_hit = dst_en && (remain[dst] > lat);
   end
endmodule

// File: rtl/iss_wb_slots.sv
module iss_wb_slots #(
   parameter int DEPTH = 26,
   parameter int REG_W = 5,
   parameter int CNT_W = 5,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] lat,
   input  logic             reserve,
   input  logic [REG_W-1:0] tag,
   output logic             clash,
   output logic             wb_valid,
   output logic [REG_W-1:0] wb_tag
);
   logic             slot_v [DEPTH];
   logic [REG_W-1:0] slot_t [DEPTH];
   logic [IDX_W-1:0] look;
   logic [IDX_W-1:0] put;

   assign put   = IDX_W'(lat);
   assign look  = put + IDX_W'(1);
   assign clash = slot_v[look];
   assign wb_valid = slot_v[0];
   assign wb_tag   = slot_t[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < DEPTH; k++) begin
            slot_v[k] <= 1'b0;
            slot_t[k] <= '0;
         end
      end else begin
         for (int k = 0; k < DEPTH - 1; k++) begin
            slot_v[k] <= slot_v[k+1];
            slot_t[k] <= slot_t[k+1];
         end
         slot_v[DEPTH-1] <= 1'b0;
         slot_t[DEPTH-1] <= '0;
         if (reserve) begin
            slot_v[put] <= 1'b1;
            slot_t[put] <= tag;
         end
      end
   end
endmodule

// File: rtl/iss_unit_busy.sv
module iss_unit_busy #(
   parameter int NUM_UNITS = 5,
   parameter int UNIT_W    = 3,
   parameter int BUSY_W    = 5,
   parameter int II_TAB [NUM_UNITS] = '{default: 1}
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic [UNIT_W-1:0]    unit,
   output logic [NUM_UNITS-1:0] busy
);
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      if (II_TAB[u] > 1) begin : g_timed
         logic [BUSY_W-1:0] left;
         always_ff @(posedge clk) begin
            if (rst)
               left <= '0;
            else if (start && unit == UNIT_W'(u))
               left <= BUSY_W'(II_TAB[u] - 1);
            else if (left != '0)
               left <= left - 1'b1;
         end
         assign busy[u] = (left != '0);
      end else begin : g_free
         assign busy[u] = 1'b0;
      end
   end
endmodule

// File: rtl/issue_hazard_ctrl.sv
module issue_hazard_ctrl #(
   parameter int NUM_REGS  = 32,
   parameter int LAT_ALU   = 0,
   parameter int LAT_LOAD  = 1,
   parameter int LAT_FADD  = 3,
   parameter int LAT_FMUL  = 6,
   parameter int LAT_FDIV  = 24,
   parameter int II_ALU    = 1,
   parameter int II_LOAD   = 1,
   parameter int II_FADD   = 1,
   parameter int II_FMUL   = 1,
   parameter int II_FDIV   = 25,
   localparam int REG_W    = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [iss_pkg::UNIT_W-1:0] in_unit,
   input  logic [REG_W-1:0]          in_dst,
   input  logic                      in_dst_en,
   input  logic [REG_W-1:0]          in_src1,
   input  logic                      in_src1_en,
   input  logic [REG_W-1:0]          in_src2,
   input  logic                      in_src2_en,
   output logic                      issue,
   output logic                      stall,
   output logic                      wb_valid,
   output logic [REG_W-1:0]          wb_tag
);
   import iss_pkg::*;

   localparam int LAT_TAB [NUM_UNITS] = '{LAT_ALU, LAT_LOAD, LAT_FADD, LAT_FMUL, LAT_FDIV};
   localparam int II_TAB  [NUM_UNITS] = '{II_ALU, II_LOAD, II_FADD, II_FMUL, II_FDIV};
   localparam int MAX_LAT = max5(LAT_ALU, LAT_LOAD, LAT_FADD, LAT_FMUL, LAT_FDIV);
   localparam int MAX_II  = max5(II_ALU, II_LOAD, II_FADD, II_FMUL, II_FDIV);
   localparam int CNT_W   = $clog2(MAX_LAT + 2);
   localparam int BUSY_W  = $clog2(MAX_II + 1);
   localparam int DEPTH   = MAX_LAT + 2;

   if (NUM_REGS != (1 << REG_W)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two");
   end
   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_par_chk
      if (II_TAB[u] < 1) begin : g_bad_ii
         $error("initiation interval must be at least one");
      end
      if (LAT_TAB[u] < 0) begin : g_bad_lat
         $error("latency must not be negative");
      end
   end

   logic [CNT_W-1:0]     lat_sel;
   logic [NUM_UNITS-1:0] busy_vec;
   logic                 unit_busy;
   logic                 raw_hit, waw_hit, clash;
   logic                 hazard;

   always_comb begin
      lat_sel   = '0;
      unit_busy = 1'b0;
      for (int u = 0; u < NUM_UNITS; u++) begin
         if (in_unit == UNIT_W'(u)) begin
            lat_sel   = CNT_W'(LAT_TAB[u]);
            unit_busy = busy_vec[u];
         end
      end
   end

   iss_pend_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W)) pend_i (
      .clk(clk), .rst(rst),
      .src1(in_src1), .src1_en(in_src1_en),
      .src2(in_src2), .src2_en(in_src2_en),
      .dst(in_dst), .dst_en(in_dst_en),
      .lat(lat_sel), .set(issue && in_dst_en),
      .raw_hit(raw_hit), .waw_hit(waw_hit)
   );

   iss_wb_slots #(.DEPTH(DEPTH), .REG_W(REG_W), .CNT_W(CNT_W)) slots_i (
      .clk(clk), .rst(rst),
      .lat(lat_sel), .reserve(issue && in_dst_en), .tag(in_dst),
      .clash(clash), .wb_valid(wb_valid), .wb_tag(wb_tag)
   );

   iss_unit_busy #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W), .BUSY_W(BUSY_W),
                   .II_TAB(II_TAB)) busy_i (
      .clk(clk), .rst(rst),
      .start(issue), .unit(in_unit), .busy(busy_vec)
   );

   assign hazard = raw_hit || waw_hit || (in_dst_en && clash) || unit_busy;
   assign issue  = in_valid && !hazard;
   assign stall  = in_valid && hazard;
endmodule

// File: rtl/iss_hazard_chk.sv
module iss_hazard_chk #(
   parameter int REG_W  = 5,
   parameter int II_DIV = 25
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [2:0]       in_unit,
   input logic [REG_W-1:0] in_dst,
   input logic             in_dst_en,
   input logic [REG_W-1:0] in_src1,
   input logic             in_src1_en,
   input logic             issue,
   input logic             stall,
   input logic             wb_valid,
   input logic [REG_W-1:0] wb_tag
);
   int since_div;

   always_ff @(posedge clk) begin
      if (rst)
         since_div <= 1 << 20;
      else if (issue && in_unit == 3'(iss_pkg::UNIT_FDIV))
         since_div <= 1;
      else if (since_div < (1 << 20))
         since_div <= since_div + 1;
   end

   AST_VALID_SPLIT: assert property (@(posedge clk) disable iff (rst)
      (issue || stall) == in_valid && !(issue && stall)); // R1

   AST_ALU_WB: assert property (@(posedge clk) disable iff (rst)
      issue && in_dst_en && in_unit == 3'(iss_pkg::UNIT_ALU)
      |=> wb_valid && wb_tag == $past(in_dst)); // R2

   AST_LOAD_RAW: assert property (@(posedge clk) disable iff (rst)
      issue && in_dst_en && in_unit == 3'(iss_pkg::UNIT_LOAD)
      |=> !(issue && in_src1_en && in_src1 == $past(in_dst))); // R3

   AST_DIV_SPACING: assert property (@(posedge clk) disable iff (rst)
      issue && in_unit == 3'(iss_pkg::UNIT_FDIV) |-> since_div >= II_DIV); // R5

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> !wb_valid); // R9
endmodule

bind issue_hazard_ctrl iss_hazard_chk #(.REG_W(5), .II_DIV(25)) chk_i (
   .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
   .in_dst(in_dst), .in_dst_en(in_dst_en), .in_src1(in_src1),
   .in_src1_en(in_src1_en), .issue(issue), .stall(stall),
   .wb_valid(wb_valid), .wb_tag(wb_tag)
);

// File: tb/issue_hazard_ctrl_tb.sv
module issue_hazard_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       in_valid = 1'b0;
   logic [2:0] in_unit = '0;
   logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
   logic       in_dst_en = 1'b0, in_src1_en = 1'b0, in_src2_en = 1'b0;
   logic       issue, stall, wb_valid;
   logic [4:0] wb_tag;

   always #10 clk = ~clk;

   issue_hazard_ctrl dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
      .in_dst(in_dst), .in_dst_en(in_dst_en),
      .in_src1(in_src1), .in_src1_en(in_src1_en),
      .in_src2(in_src2), .in_src2_en(in_src2_en),
      .issue(issue), .stall(stall), .wb_valid(wb_valid), .wb_tag(wb_tag)
   );

   int LAT [5] = '{0, 1, 3, 6, 24};
   int ready_at [32];
   int resv [int];
   int div_free;
   int n = 0;
   int tests = 0;
   int fails = 0;
   bit done = 0;

   task automatic model_clear();
      foreach (ready_at[i]) ready_at[i] = -1000;
      resv.delete();
      div_free = -1000;
   endtask

   function automatic bit model_hazard(int unit, int dst, bit den,
                                       int s1, bit s1en, int s2, bit s2en);
      int wb;
      bit h;
      wb = n + LAT[unit] + 1;
      h = 0;
      if (s1en && ready_at[s1] > n) h = 1;
      if (s2en && ready_at[s2] > n) h = 1;
      if (den && ready_at[dst] >= wb) h = 1;
      if (den && resv.exists(wb)) h = 1;
      if (unit == 4 && n < div_free) h = 1;
      return h;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, n);
      end
   endtask

   task automatic cycle(string tag, bit v, int unit, int dst, bit den,
                        int s1, bit s1en, int s2, bit s2en, output bit issued);
      bit hz, exp_i, exp_wb;
      in_valid = v; in_unit = 3'(unit); in_dst = 5'(dst); in_dst_en = den;
      in_src1 = 5'(s1); in_src1_en = s1en; in_src2 = 5'(s2); in_src2_en = s2en;
      #2;
      hz = model_hazard(unit, dst, den, s1, s1en, s2, s2en);
      exp_i = v && !hz;
      check(tag, "issue", int'(issue), int'(exp_i));
      check(tag, "stall", int'(stall), int'(v && hz));
      exp_wb = resv.exists(n);
      check("R2", "wb_valid", int'(wb_valid), int'(exp_wb));
      if (exp_wb) check("R2", "wb_tag", int'(wb_tag), resv[n]);
      @(posedge clk);
      if (exp_i) begin
         if (den) begin
            ready_at[dst] = n + LAT[unit] + 1;
            resv[n + LAT[unit] + 1] = dst;
         end
         if (unit == 4) div_free = n + 25;
      end
      if (resv.exists(n)) resv.delete(n);
      n++;
      @(negedge clk);
      issued = exp_i;
   endtask

   task automatic run_instr(string tag, int unit, int dst, bit den,
                            int s1, bit s1en, int s2, bit s2en, output int waited);
      bit ok;
      waited = 0;
      ok = 0;
      while (!ok && waited < 100) begin
         cycle(tag, 1'b1, unit, dst, den, s1, s1en, s2, s2en, ok);
         if (!ok) waited++;
      end
   endtask

   task automatic idle(int k);
      bit d;
      for (int i = 0; i < k; i++) cycle("R1", 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, 1'b0, d);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      in_valid = 1'b0;
      for (int i = 0; i < 2; i++) begin
         @(posedge clk);
         n++;
      end
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL R1 watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int w;
      model_clear();
      @(negedge clk);
      do_reset();
      // R9: quiet after reset
      idle(3);

      // R2: each unit's writeback timing (model compares the strobe each cycle)
      run_instr("R2", 0, 1, 1, 0, 0, 0, 0, w);
      idle(3);
      run_instr("R2", 1, 2, 1, 0, 0, 0, 0, w);
      idle(4);
      run_instr("R2", 2, 3, 1, 0, 0, 0, 0, w);
      idle(6);
      run_instr("R2", 3, 4, 1, 0, 0, 0, 0, w);
      idle(9);
      run_instr("R2", 4, 5, 1, 0, 0, 0, 0, w);
      idle(30);

      // R3: load then dependent ALU waits one cycle
      run_instr("R3", 1, 1, 1, 0, 0, 0, 0, w);
      run_instr("R3", 0, 11, 1, 1, 1, 0, 0, w);
      check("R3", "load consumer stalls", w, 1);
      idle(5);
      // R3: multiply then dependent add waits six cycles
      run_instr("R3", 3, 2, 1, 0, 0, 0, 0, w);
      run_instr("R3", 2, 10, 1, 0, 0, 2, 1, w);
      check("R3", "mul consumer stalls", w, 6);
      idle(10);

      // R4: back-to-back pipelined multiplies and adds
      run_instr("R4", 3, 16, 1, 0, 0, 0, 0, w);
      for (int i = 0; i < 3; i++) begin
         run_instr("R4", 3, 17 + i, 1, 0, 0, 0, 0, w);
         check("R4", "mul back-to-back stalls", w, 0);
      end
      idle(10);

      // R5: two divides
      run_instr("R5", 4, 20, 1, 0, 0, 0, 0, w);
      run_instr("R5", 4, 21, 1, 0, 0, 0, 0, w);
      check("R5", "second divide stalls", w, 24);
      idle(30);

      // R6: load then ALU collide on one writeback cycle
      run_instr("R6", 1, 5, 1, 0, 0, 0, 0, w);
      run_instr("R6", 0, 6, 1, 0, 0, 0, 0, w);
      check("R6", "alu after load stalls", w, 1);
      idle(5);
      // R6: multiply then add three cycles later
      run_instr("R6", 3, 3, 1, 0, 0, 0, 0, w);
      idle(2);
      run_instr("R6", 2, 4, 1, 0, 0, 0, 0, w);
      check("R6", "add colliding with mul stalls", w, 1);
      idle(10);

      // R7: ALU write behind a pending multiply to the same register
      run_instr("R7", 3, 7, 1, 0, 0, 0, 0, w);
      run_instr("R7", 0, 7, 1, 0, 0, 0, 0, w);
      check("R7", "waw stall", w, 6);
      idle(5);

      // R8: disabled sources naming a pending register
      run_instr("R8", 3, 8, 1, 0, 0, 0, 0, w);
      run_instr("R8", 0, 9, 1, 8, 0, 8, 0, w);
      check("R8", "disabled sources do not stall", w, 0);
      idle(10);

      // R10: no destination means no waw and no port stall
      run_instr("R10", 3, 12, 1, 0, 0, 0, 0, w);
      run_instr("R10", 0, 12, 0, 0, 0, 0, 0, w);
      check("R10", "no-dst writer after mul", w, 0);
      idle(8);
      run_instr("R10", 1, 13, 1, 0, 0, 0, 0, w);
      run_instr("R10", 0, 14, 0, 0, 0, 0, 0, w);
      check("R10", "no-dst alu after load", w, 0);
      idle(5);

      // R9: reset with work in flight
      run_instr("R9", 4, 14, 1, 0, 0, 0, 0, w);
      run_instr("R9", 3, 15, 1, 0, 0, 0, 0, w);
      do_reset();
      idle(2);
      run_instr("R9", 4, 14, 1, 14, 1, 15, 1, w);
      check("R9", "divide after reset", w, 0);
      idle(30);

      // R1: mixed stream over eight registers
      for (int i = 0; i < 400; i++) begin
         int u;
         u = int'($urandom_range(0, 9));
         if (u > 3) u = (u == 9) ? 4 : u % 4;
         if ($urandom_range(0, 4) == 0) idle(1);
         run_instr("R1", u, int'($urandom_range(0, 7)), 1'($urandom_range(0, 3) != 0),
                   int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                   int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), w);
      end
      idle(30);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule